// File: doc/BRIEF.md
# Receive Gain-Reduction Stepper

This block holds the gain-reduction state of a receive chain as one code between 0 and 10 and turns it into two control steps: a comparator-window step and an amplifier gain-reduction step. The lower codes widen the digitizing window one 3 dB step at a time. Once the window is at its widest, each further code removes another 3 dB of gain from the second and third amplifier stages. While a receive-window qualifier is high, the block watches the output of a wide-window comparator. Every time that output toggles, it raises the code by one, so the gain keeps dropping until the comparator stops toggling.

A reception starts on the rising edge of the qualifier. At that edge the code that was in force is copied into a snapshot register, and the code is then loaded with a start value. One algorithm starts from the widest-window, full-gain point (code 4), which is the faster choice. The other starts from code 0. The block can run for the whole window or only until eight sub-carrier pulses have been counted. The intended tie-offs are: controller enabled, whole-window mode, and the code-4 start. When the qualifier falls, or when a reset-gain command arrives, the code is reloaded from the configured initial value. Every increment produces a one-cycle pulse, which a signal-strength tracker can use to restart its measurement.

Top module: `rx_gain_stepper`

## Requirements
- R1: `gainCode` never exceeds 10. `winStep` equals min(code, 4). `gainStep` equals code minus 4 when the code is above 4, and 0 otherwise.
- R2: While `rstN` is low, and in the first cycle after it is released, `gainCode`, `snapshot` and `reducePulse` are all 0.
- R3: At a clock edge where `rxWindow` is 1 and was 0 at the previous edge (a rise), `snapshot` takes the code held before that edge.
- R4: At a rise with `agcEnable`=1 and no reset-gain command, the code becomes 4 when `presetStart`=1 and 0 when `presetStart`=0.
- R5: At an edge where `rxWindow` was 1 at both this edge and the previous one, `agcEnable`=1, and `wideCmp` differs from its value at the previous edge, the code rises by one and `reducePulse` is 1 for exactly that cycle. This does not happen once the code is 10.
- R6: In the cycle right after an increment, no increment is taken, even if `wideCmp` toggles again.
- R7: With `wholeWindow`=0, increments are allowed only while fewer than eight cycles with `subPulse`=1 have been counted since the rise. The count ignores the rise cycle itself. With `wholeWindow`=1, the count has no effect.
- R8: At an edge where `rxWindow` is 0 and was 1 at the previous edge, the code is loaded with `initCode`, clamped to 10.
- R9: `resetGainCmd`=1 loads the clamped `initCode` at that edge. It takes priority over start loads and increments.
- R10: With `agcEnable`=0, a rise does not change the code and toggles of `wideCmp` cause no increment. Snapshot, fall and command loads still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| agcEnable | input | 1 | Enables start loads and increments |
| wholeWindow | input | 1 | 1: run for the whole window; 0: run only for the first eight pulses |
| presetStart | input | 1 | 1: start at code 4; 0: start at code 0 |
| initCode | input | 4 | Reload value for fall and command loads (clamped to 10) |
| resetGainCmd | input | 1 | Reload the code from `initCode` |
| rxWindow | input | 1 | Receive-window qualifier |
| wideCmp | input | 1 | Wide-window comparator output |
| subPulse | input | 1 | Sub-carrier pulse indicator, one cycle per pulse |
| gainCode | output | 4 | Current state code, 0..10 |
| winStep | output | 3 | Digitizer window step, 0..4 |
| gainStep | output | 3 | Amplifier gain-reduction step, 0..6 |
| reducePulse | output | 1 | One-cycle strobe on every increment |
| snapshot | output | 4 | Code captured at the last rise of `rxWindow` |

## Verification
The embedded assertions check, on every cycle, the following: the code stays within range; the window and gain steps stay consistent with each other; each increment is exactly +1 and is never followed at once by another; and the snapshot, start and reload values follow their triggering edges. The pulse counter's bound is also checked continuously. Other behaviour shows only in the bench scenarios, which compare every cycle against a behavioural model. These scenarios cover saturation at 10 under a continuously toggling comparator, toggles that stop the climb part way, the cut-off after the eighth pulse, a disabled controller ignoring toggles, and reset-gain commands that land in the middle of a reception.

// File: rtl/rx_gain_pkg.sv
package rx_gain_pkg;

  // Strobes from the control to the code datapath, one cycle each.
  typedef struct packed {
    logic loadInit;   // reload from configured initial code
    logic loadStart;  // load the start code at reception start
    logic stepUp;     // increment the code by one
    logic takeSnap;   // capture the current code
  } gainStrobes_t;

endpackage

// File: rtl/rx_gain_ctrl.sv
module rx_gain_ctrl #(
  parameter int PULSE_LIMIT = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      agcEnable,
  input  logic                      wholeWindow,
  input  logic                      resetGainCmd,
  input  logic                      rxWindow,
  input  logic                      wideCmp,
  input  logic                      subPulse,
  input  logic                      atMax,
  input  logic                      stepBusy,
  output rx_gain_pkg::gainStrobes_t strobes
);
  localparam int CNT_W = $clog2(PULSE_LIMIT + 1);

  logic             rxWindowD;
  logic             wideCmpD;
  logic [CNT_W-1:0] pulseCnt;
  logic             winRise;
  logic             winFall;
  logic             cmpToggle;
  logic             pulseOpen;
  logic             stepOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxWindowD <= 1'b0;
      wideCmpD  <= 1'b0;
    end else begin
      rxWindowD <= rxWindow;
      wideCmpD  <= wideCmp;
    end
  end

  assign winRise   = rxWindow & ~rxWindowD;
  assign winFall   = ~rxWindow & rxWindowD;
  assign cmpToggle = wideCmp ^ wideCmpD;
  assign pulseOpen = (pulseCnt < CNT_W'(PULSE_LIMIT));

  // Sub-carrier pulse counter, restarted at each reception start.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (winRise) begin
      pulseCnt <= '0;
    end else if (rxWindow && subPulse && pulseOpen) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  assign stepOk = agcEnable & rxWindow & rxWindowD & (wholeWindow | pulseOpen)
                & ~stepBusy & ~atMax & cmpToggle;

  always_comb begin
    strobes           = '0;
    strobes.takeSnap  = winRise;
    strobes.loadInit  = resetGainCmd | winFall;
    strobes.loadStart = winRise & agcEnable & ~resetGainCmd;
    strobes.stepUp    = stepOk & ~resetGainCmd;
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= CNT_W'(PULSE_LIMIT));

  assert_closed_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!wholeWindow && !pulseOpen) |-> !strobes.stepUp);

  assert_enable_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    !agcEnable |-> !(strobes.stepUp || strobes.loadStart));

endmodule

// File: rtl/rx_gain_path.sv
module rx_gain_path #(
  parameter int MAX_CODE    = 10,
  parameter int PRESET_CODE = 4,
  parameter int CODE_W      = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  rx_gain_pkg::gainStrobes_t strobes,
  input  logic                      presetStart,
  input  logic [CODE_W-1:0]         initCode,
  output logic [CODE_W-1:0]         gainCode,
  output logic [CODE_W-1:0]         snapshot,
  output logic                      reducePulse,
  output logic                      atMax
);
  logic [CODE_W-1:0] initClamped;
  logic [CODE_W-1:0] startCode;
  logic [CODE_W-1:0] codeNext;
  logic              pulseNext;

  assign initClamped = (initCode > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : initCode;
  assign startCode   = presetStart ? CODE_W'(PRESET_CODE) : '0;
  assign atMax       = (gainCode >= CODE_W'(MAX_CODE));

  always_comb begin
    codeNext  = gainCode;
    pulseNext = 1'b0;
    if (strobes.loadInit) begin
      codeNext = initClamped;
    end else if (strobes.loadStart) begin
      codeNext = startCode;
    end else if (strobes.stepUp) begin
      codeNext  = gainCode + 1'b1;
      pulseNext = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainCode    <= '0;
      reducePulse <= 1'b0;
    end else begin
      gainCode    <= codeNext;
      reducePulse <= pulseNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapshot <= '0;
    end else if (strobes.takeSnap) begin
      snapshot <= gainCode;
    end
  end

  assert_code_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    gainCode <= CODE_W'(MAX_CODE));

  assert_step_plus_one_R5: assert property (@(posedge clk) disable iff (!rstN)
    reducePulse |-> (gainCode == $past(gainCode) + 1'b1));

  assert_step_spacing_R6: assert property (@(posedge clk) disable iff (!rstN)
    reducePulse |=> !reducePulse);

endmodule

// File: rtl/rx_gain_decode.sv
module rx_gain_decode #(
  parameter int WIN_STEPS  = 4,
  parameter int GAIN_STEPS = 6,
  parameter int CODE_W     = 4,
  parameter int WIN_W      = 3,
  parameter int GAIN_W     = 3
) (
  input  logic [CODE_W-1:0] gainCode,
  output logic [WIN_W-1:0]  winStep,
  output logic [GAIN_W-1:0] gainStep
);
  localparam int MAX_CODE = WIN_STEPS + GAIN_STEPS;

  // Window widens first; gain cut starts after the window is fully open.
  always_comb begin
    if (gainCode >= CODE_W'(WIN_STEPS)) begin
      winStep = WIN_W'(WIN_STEPS);
    end else begin
      winStep = WIN_W'(gainCode);
    end
  end

  always_comb begin
    if (gainCode > CODE_W'(MAX_CODE)) begin
      gainStep = GAIN_W'(GAIN_STEPS);
    end else if (gainCode > CODE_W'(WIN_STEPS)) begin
      gainStep = GAIN_W'(gainCode - CODE_W'(WIN_STEPS));
    end else begin
      gainStep = '0;
    end
  end

endmodule

// File: rtl/rx_gain_stepper.sv
module rx_gain_stepper #(
  parameter int WIN_STEPS   = 4,
  parameter int GAIN_STEPS  = 6,
  parameter int PULSE_LIMIT = 8,
  parameter int CODE_W      = $clog2(WIN_STEPS + GAIN_STEPS + 1),
  parameter int WIN_W       = $clog2(WIN_STEPS + 1),
  parameter int GAIN_W      = $clog2(GAIN_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              agcEnable,
  input  logic              wholeWindow,
  input  logic              presetStart,
  input  logic [CODE_W-1:0] initCode,
  input  logic              resetGainCmd,
  input  logic              rxWindow,
  input  logic              wideCmp,
  input  logic              subPulse,
  output logic [CODE_W-1:0] gainCode,
  output logic [WIN_W-1:0]  winStep,
  output logic [GAIN_W-1:0] gainStep,
  output logic              reducePulse,
  output logic [CODE_W-1:0] snapshot
);
  localparam int MAX_CODE = WIN_STEPS + GAIN_STEPS;

  rx_gain_pkg::gainStrobes_t strobes;
  logic                      atMax;

  rx_gain_ctrl #(.PULSE_LIMIT(PULSE_LIMIT)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .agcEnable    (agcEnable),
    .wholeWindow  (wholeWindow),
    .resetGainCmd (resetGainCmd),
    .rxWindow     (rxWindow),
    .wideCmp      (wideCmp),
    .subPulse     (subPulse),
    .atMax        (atMax),
    .stepBusy     (reducePulse),
    .strobes      (strobes)
  );

  rx_gain_path #(
    .MAX_CODE    (MAX_CODE),
    .PRESET_CODE (WIN_STEPS),
    .CODE_W      (CODE_W)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .presetStart (presetStart),
    .initCode    (initCode),
    .gainCode    (gainCode),
    .snapshot    (snapshot),
    .reducePulse (reducePulse),
    .atMax       (atMax)
  );

  rx_gain_decode #(
    .WIN_STEPS  (WIN_STEPS),
    .GAIN_STEPS (GAIN_STEPS),
    .CODE_W     (CODE_W),
    .WIN_W      (WIN_W),
    .GAIN_W     (GAIN_W)
  ) u_decode (
    .gainCode (gainCode),
    .winStep  (winStep),
    .gainStep (gainStep)
  );

  function automatic logic [CODE_W-1:0] clampCode(input logic [CODE_W-1:0] val);
    return (val > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : val;
  endfunction

  assert_steps_ordered_R1: assert property (@(posedge clk) disable iff (!rstN)
    (gainStep != '0) |-> (winStep == WIN_W'(WIN_STEPS)));

  assert_snap_on_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxWindow && !$past(rxWindow)) |=> (snapshot == $past(gainCode)));

  assert_start_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxWindow && !$past(rxWindow) && agcEnable && !resetGainCmd)
      |=> (gainCode == (($past(presetStart)) ? CODE_W'(WIN_STEPS) : '0)));

  assert_fall_reload_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!rxWindow && $past(rxWindow)) |=> (gainCode == clampCode($past(initCode))));

  assert_cmd_reload_R9: assert property (@(posedge clk) disable iff (!rstN)
    resetGainCmd |=> (gainCode == clampCode($past(initCode))));

endmodule

// File: tb/rx_gain_stepper_bench.sv
module rx_gain_stepper_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       agcEnable = 1'b1;
  logic       wholeWindow = 1'b1;
  logic       presetStart = 1'b1;
  logic [3:0] initCode = 4'd0;
  logic       resetGainCmd = 1'b0;
  logic       rxWindow = 1'b0;
  logic       wideCmp = 1'b0;
  logic       subPulse = 1'b0;
  logic [3:0] gainCode;
  logic [2:0] winStep;
  logic [2:0] gainStep;
  logic       reducePulse;
  logic [3:0] snapshot;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R2";

  // behavioural model state
  int mCode = 0, mSnap = 0, mPulse = 0, mCnt = 0, mWinD = 0, mCmpD = 0;

  always #10 clk = ~clk;  // 50 MHz

  rx_gain_stepper u_rx_gain_stepper (
    .clk(clk), .rstN(rstN), .agcEnable(agcEnable), .wholeWindow(wholeWindow),
    .presetStart(presetStart), .initCode(initCode), .resetGainCmd(resetGainCmd),
    .rxWindow(rxWindow), .wideCmp(wideCmp), .subPulse(subPulse),
    .gainCode(gainCode), .winStep(winStep), .gainStep(gainStep),
    .reducePulse(reducePulse), .snapshot(snapshot)
  );

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    int expWin, expGain;
    expWin  = (mCode > 4) ? 4 : mCode;
    expGain = (mCode > 4) ? mCode - 4 : 0;
    checkVal(tag, "gainCode", gainCode, mCode);
    checkVal("R1", "winStep", winStep, expWin);
    checkVal("R1", "gainStep", gainStep, expGain);
    checkVal(tag, "reducePulse", reducePulse, mPulse);
    checkVal("R3", "snapshot", snapshot, mSnap);
  endtask

  // one clock: model next state from present inputs, then compare after the edge
  task automatic tick();
    int nCode, nSnap, nPulse, nCnt, clampInit;
    bit rise, fall, tog;
    rise = rxWindow && (mWinD == 0);
    fall = !rxWindow && (mWinD == 1);
    tog  = (int'(wideCmp) != mCmpD);
    clampInit = (initCode > 10) ? 10 : int'(initCode);
    nCode = mCode; nSnap = mSnap; nPulse = 0; nCnt = mCnt;
    if (rise) nSnap = mCode;
    if (rise) nCnt = 0;
    else if (rxWindow && subPulse && mCnt < 8) nCnt = mCnt + 1;
    if (resetGainCmd || fall) nCode = clampInit;
    else if (rise && agcEnable) nCode = presetStart ? 4 : 0;
    else if (agcEnable && rxWindow && mWinD == 1 && (wholeWindow || mCnt < 8)
             && mPulse == 0 && mCode < 10 && tog) begin
      nCode = mCode + 1;
      nPulse = 1;
    end
    @(posedge clk);
    #2;
    if (!rstN) begin
      mCode = 0; mSnap = 0; mPulse = 0; mCnt = 0; mWinD = 0; mCmpD = 0;
    end else begin
      mCode = nCode; mSnap = nSnap; mPulse = nPulse; mCnt = nCnt;
      mWinD = int'(rxWindow); mCmpD = int'(wideCmp);
    end
    compareAll();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2: reset state
    ticks(3);
    checkVal("R2", "reset gainCode", gainCode, 0);
    checkVal("R2", "reset snapshot", snapshot, 0);
    rstN = 1'b1;
    tick();
    checkVal("R2", "released gainCode", gainCode, 0);

    // R9: command reload
    tag = "R9";
    initCode = 4'd2; resetGainCmd = 1'b1; tick(); resetGainCmd = 1'b0;
    checkVal("R9", "cmd load", gainCode, 2);
    ticks(2);

    // R3/R4: rise with preset start; R5/R6: continuous toggling saturates
    tag = "R4";
    rxWindow = 1'b1; tick();
    checkVal("R4", "preset start", gainCode, 4);
    checkVal("R3", "snapshot at rise", snapshot, 2);
    tag = "R5";
    for (int i = 0; i < 20; i++) begin wideCmp = ~wideCmp; tick(); end
    checkVal("R5", "saturated code", gainCode, 10);
    checkVal("R1", "max winStep", winStep, 4);
    checkVal("R1", "max gainStep", gainStep, 6);
    ticks(2);
    tag = "R8";
    initCode = 4'd3; rxWindow = 1'b0; tick();
    checkVal("R8", "fall reload", gainCode, 3);
    ticks(2);

    // R4: zero start, sparse toggles, climb stops when toggles stop
    tag = "R4";
    presetStart = 1'b0; rxWindow = 1'b1; tick();
    checkVal("R4", "zero start", gainCode, 0);
    checkVal("R3", "snapshot keeps old code", snapshot, 3);
    tag = "R5";
    for (int i = 0; i < 3; i++) begin wideCmp = ~wideCmp; tick(); tick(); tick(); end
    ticks(5);
    checkVal("R5", "three sparse steps", gainCode, 3);
    // R6: toggle on the cycle right after a step is dropped
    tag = "R6";
    wideCmp = ~wideCmp; tick(); wideCmp = ~wideCmp; tick();
    checkVal("R6", "second toggle blocked", gainCode, 4);
    ticks(2);
    rxWindow = 1'b0; ticks(2);

    // R7: first-eight-pulse mode
    tag = "R7";
    wholeWindow = 1'b0; presetStart = 1'b1; rxWindow = 1'b1; tick();
    for (int i = 0; i < 8; i++) begin subPulse = 1'b1; tick(); subPulse = 1'b0; tick(); end
    for (int i = 0; i < 6; i++) begin wideCmp = ~wideCmp; tick(); tick(); end
    checkVal("R7", "no steps after eight pulses", gainCode, 4);
    rxWindow = 1'b0; ticks(2);
    rxWindow = 1'b1; tick();
    for (int i = 0; i < 4; i++) begin
      subPulse = 1'b1; wideCmp = ~wideCmp; tick(); subPulse = 1'b0; tick();
    end
    checkVal("R7", "steps inside first pulses", gainCode, 8);
    rxWindow = 1'b0; ticks(2);
    wholeWindow = 1'b1;

    // R10: disabled controller ignores rise and toggles
    tag = "R10";
    agcEnable = 1'b0; initCode = 4'd1; resetGainCmd = 1'b1; tick(); resetGainCmd = 1'b0;
    rxWindow = 1'b1; tick();
    checkVal("R10", "no start load", gainCode, 1);
    for (int i = 0; i < 6; i++) begin wideCmp = ~wideCmp; tick(); tick(); end
    checkVal("R10", "no steps when disabled", gainCode, 1);
    rxWindow = 1'b0; tick(); agcEnable = 1'b1;

    // R9: clamp and priority over steps within a window
    tag = "R9";
    initCode = 4'd15; resetGainCmd = 1'b1; tick(); resetGainCmd = 1'b0;
    checkVal("R9", "clamped load", gainCode, 10);
    initCode = 4'd6; rxWindow = 1'b1; tick();
    wideCmp = ~wideCmp; resetGainCmd = 1'b1; tick(); resetGainCmd = 1'b0;
    checkVal("R9", "cmd beats step", gainCode, 6);
    checkVal("R9", "no pulse on cmd", reducePulse, 0);
    ticks(3);
    rxWindow = 1'b0; ticks(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule